// File: doc/BRIEF.md
# Three-State Bus Cycle Unit with Peripheral Bus Handoff

This block sits between a processor core and its external memory bus. The core hands it one transfer at a time, either a read or a write. The unit runs each transfer as a bus cycle of three clock states, T1, T2 and T3, and adds wait states while the memory holds its wait line high. In T1 the unit puts the address on the bus together with an address-valid strobe. It keeps both in place until the cycle ends. From T2 onward it raises either the read or the write strobe. A read returns its data to the core one cycle after T3.

The unit also shares the bus with a direct-memory-access peripheral through a request/grant handshake. It grants the bus only when three things hold at once: the core reports the end of an instruction, no higher-priority interrupt is pending, and no bus cycle is in progress. While the grant is active, every address, data and control driver of the unit is released, and core requests wait. When the peripheral drops its request, the unit withdraws the grant one edge later and starts serving the core again.

Top module: `bus_cycle_unit`

## Requirements
- R1: After reset, `dma_gnt`, `bus_as`, `bus_rd`, `bus_wr`, `bus_data_oe` and `core_done` are low, `bus_addr_oe` and `bus_ctl_oe` are high, and `core_ready` is high.
- R2: `core_ready` is high only when no bus cycle is in progress, no grant is active, and no grant is being taken in that cycle. A cycle where `core_req` and `core_ready` are both high accepts the transfer, and the next cycle is T1.
- R3: `bus_as` is high from T1 through T3 inclusive. `bus_addr` carries the accepted address for that whole span and reads zero whenever `bus_as` is low.
- R4: `bus_wait` is sampled at the end of T2 and at the end of every wait state. Each high sample inserts one wait state before T3, so a cycle with no wait lasts exactly three clocks. The read strobe (`bus_rd`, for `core_write`=0) or the write strobe (`bus_wr`, for `core_write`=1) is high from T2 through T3.
- R5: `bus_data_oe` is high exactly while `bus_wr` is high. During that time `bus_wdata` carries the accepted write data; otherwise it is zero.
- R6: `bus_rdata` is captured at the end of T3 of a read. In the next cycle `core_done` pulses high for one cycle, with `core_rdata` showing the captured value. Writes also pulse `core_done`.
- R7: When `instr_boundary`, `dma_req` and the inverse of `irq_pending` are all high in a cycle with no bus cycle in progress, `dma_gnt` rises at the next edge.
- R8: A boundary pulse seen while `irq_pending` is high, and a `dma_req` raised between boundary pulses, grant nothing. The request waits for a later qualifying boundary.
- R9: While `dma_gnt` is high, `bus_addr_oe`, `bus_ctl_oe`, `bus_data_oe`, `bus_as`, `bus_rd`, `bus_wr` and `core_ready` are all low.
- R10: `dma_gnt` falls at the edge after the one where `dma_req` is sampled low. `core_ready` stays low in that cycle, so no bus cycle starts before the grant is gone.
- R11: A qualifying boundary arriving together with `core_req` gives the bus to the peripheral. The core transfer is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core asks for a bus cycle |
| core_write | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Transfer address |
| core_wdata | input | DATA_W | Write data |
| core_ready | output | 1 | Unit accepts a request this cycle |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Last captured read data |
| instr_boundary | input | 1 | Single-cycle end-of-instruction pulse |
| irq_pending | input | 1 | Higher-priority interrupt pending |
| bus_addr | output | ADDR_W | Address bus |
| bus_addr_oe | output | 1 | Address driver enable |
| bus_as | output | 1 | Address-valid strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ctl_oe | output | 1 | Strobe driver enable |
| bus_wdata | output | DATA_W | Write data bus |
| bus_data_oe | output | 1 | Data driver enable |
| bus_rdata | input | DATA_W | Read data bus |
| bus_wait | input | 1 | Memory wait line |
| dma_req | input | 1 | Peripheral bus request |
| dma_gnt | output | 1 | Bus grant to the peripheral |

## Verification
The bench builds the unit with a 10-bit address and 8-bit data. Random addresses and data at these widths often hit all-zero and all-ones values, so a dropped or stuck bit shows up quickly. The random phase varies the wait-state count and interleaves boundary pulses, pending interrupts and sticky peripheral requests. This reaches the cases where a request, a grant and a cycle end fall on the same edge. Directed steps before that phase force the interrupt block, the release edge and the case where the core and the peripheral ask for the bus together.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4
  } bcu_phase_e;
endpackage

// File: rtl/bcu_sequencer.sv
module bcu_sequencer
  import bcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_wait,
  output logic in_cycle,
  output logic strobe_win,
  output logic last_state
);
  bcu_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2,
      PH_TW:   phase_d = bus_wait ? PH_TW : PH_T3;
      PH_T3:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign in_cycle   = (phase_q != PH_IDLE);
  assign strobe_win = (phase_q == PH_T2) || (phase_q == PH_TW) || (phase_q == PH_T3);
  assign last_state = (phase_q == PH_T3);

  // R4: a high wait sample in T2 keeps the strobe window open next cycle
  a_r4_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T2 && bus_wait) |=> (strobe_win && !last_state));

  // R2: an accepted start always leads into T1
  a_r2_start_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_cycle) |=> (phase_q == PH_T1));
endmodule

// File: rtl/bcu_arbiter.sv
module bcu_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_idle,
  input  logic instr_boundary,
  input  logic irq_pending,
  input  logic dma_req,
  output logic grant_take,
  output logic dma_gnt
);
  logic gnt_q, gnt_d;

  assign grant_take = !gnt_q && bus_idle && instr_boundary && dma_req && !irq_pending;

  always_comb begin
    gnt_d = gnt_q;
    if (gnt_q) begin
      if (!dma_req) gnt_d = 1'b0;
    end else if (grant_take) begin
      gnt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= gnt_d;
  end

  assign dma_gnt = gnt_q;

  // R7 / R8: a rising grant needs a qualifying boundary in the previous cycle
  a_r7_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt) |-> $past(instr_boundary && dma_req && !irq_pending && bus_idle));

  // R10: a dropped request removes the grant at the next edge
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !dma_req) |=> !dma_gnt);
endmodule

// File: rtl/bcu_datapath.sv
module bcu_datapath #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_cycle,
  input  logic              strobe_win,
  input  logic              last_state,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, done_q;
  logic              cap_req, cap_rd;

  assign cap_req = start;
  assign cap_rd  = last_state && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (cap_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last_state;
  end

  assign bus_addr  = in_cycle ? addr_q : '0;
  assign bus_rd    = strobe_win && !wr_q;
  assign bus_wr    = strobe_win && wr_q;
  assign bus_wdata = (strobe_win && wr_q) ? wdata_q : '0;
  assign done      = done_q;
  assign rdata     = rdata_q;

  // R6: the completion pulse lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: the address stays put while the cycle runs
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle && $past(in_cycle)) |-> $stable(bus_addr));
endmodule

// File: rtl/bus_cycle_unit.sv
module bus_cycle_unit #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_write,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              instr_boundary,
  input  logic              irq_pending,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_as,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_ctl_oe,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_wait,
  input  logic              dma_req,
  output logic              dma_gnt
);
  localparam int SyncW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [SyncW-1:0] rst_sync_q;
  logic             rst_int_n;

  generate
    if (SyncW == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= 1'b0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SyncW-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SyncW-1];

  logic in_cycle, strobe_win, last_state, grant_take, start, wr_int;

  assign core_ready = !in_cycle && !dma_gnt && !grant_take;
  assign start      = core_req && core_ready;

  bcu_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .bus_wait   (bus_wait),
    .in_cycle   (in_cycle),
    .strobe_win (strobe_win),
    .last_state (last_state)
  );

  bcu_arbiter u_arb (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .bus_idle       (!in_cycle),
    .instr_boundary (instr_boundary),
    .irq_pending    (irq_pending),
    .dma_req        (dma_req),
    .grant_take     (grant_take),
    .dma_gnt        (dma_gnt)
  );

  bcu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .in_cycle   (in_cycle),
    .strobe_win (strobe_win),
    .last_state (last_state),
    .req_write  (core_write),
    .req_addr   (core_addr),
    .req_wdata  (core_wdata),
    .bus_rdata  (bus_rdata),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_wr     (wr_int),
    .done       (core_done),
    .rdata      (core_rdata)
  );

  assign bus_wr      = wr_int;
  assign bus_as      = in_cycle;
  assign bus_data_oe = wr_int;
  assign bus_addr_oe = !dma_gnt;
  assign bus_ctl_oe  = !dma_gnt;

  // R9: nothing is driven while the peripheral owns the bus
  a_r9_floated: assert property (@(posedge clk) disable iff (!rst_int_n)
    dma_gnt |-> (!bus_as && !bus_rd && !bus_wr && !bus_data_oe && !core_ready));

  // R2: acceptance only from an idle, ungranted bus
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    core_ready |-> (!bus_as && !dma_gnt));

  // R5: the data driver follows the write strobe
  a_r5_data_drive: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_data_oe |-> (bus_as && !bus_rd));
endmodule

// File: tb/bus_cycle_unit_test.sv
module bus_cycle_unit_test;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req = 0, core_write = 0, instr_boundary = 0, irq_pending = 0;
  logic bus_wait = 0, dma_req = 0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, bus_rdata = '0;
  logic core_ready, core_done, bus_addr_oe, bus_as, bus_rd, bus_wr, bus_ctl_oe;
  logic bus_data_oe, dma_gnt;
  logic [DW-1:0] core_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_cycle_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_write(core_write),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
    .core_done(core_done), .core_rdata(core_rdata),
    .instr_boundary(instr_boundary), .irq_pending(irq_pending),
    .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_as(bus_as),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ctl_oe(bus_ctl_oe),
    .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .dma_req(dma_req), .dma_gnt(dma_gnt)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase number 0 idle, 1 T1, 2 T2, 3 wait, 4 T3
  int            m_ph = 0;
  bit            m_g = 0, m_w = 0, m_done = 0;
  logic [AW-1:0] m_a = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;

  function automatic bit m_take();
    return (m_ph == 0) && !m_g && instr_boundary && dma_req && !irq_pending;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_g = 0; m_w = 0; m_done = 0; m_a = '0; m_wd = '0; m_rd = '0;
    end else begin
      bit take;
      take   = m_take();
      m_done = (m_ph == 4);
      if (m_ph == 4 && !m_w) m_rd = bus_rdata;
      case (m_ph)
        0: begin
          if (m_g) begin
            if (!dma_req) m_g = 0;
          end else if (take) m_g = 1;
          else if (core_req) begin
            m_a = core_addr; m_wd = core_wdata; m_w = core_write; m_ph = 1;
          end
        end
        1: m_ph = 2;
        2, 3: m_ph = bus_wait ? 3 : 4;
        default: m_ph = 0;
      endcase
    end
  end

  bit compare_on = 0;
  always @(negedge clk) begin
    if (compare_on && !finished) begin
      bit strobe;
      strobe = (m_ph >= 2);
      check("R2", "core_ready", core_ready, (m_ph == 0) && !m_g && !m_take());
      check("R3", "bus_as", bus_as, m_ph != 0);
      check("R3", "bus_addr", bus_addr, (m_ph != 0) ? m_a : '0);
      check("R4", "bus_rd", bus_rd, strobe && !m_w);
      check("R4", "bus_wr", bus_wr, strobe && m_w);
      check("R5", "bus_data_oe", bus_data_oe, strobe && m_w);
      check("R5", "bus_wdata", bus_wdata, (strobe && m_w) ? m_wd : '0);
      check("R6", "core_done", core_done, m_done);
      if (m_done && !m_w) check("R6", "core_rdata", core_rdata, m_rd);
      check("R7", "dma_gnt", dma_gnt, m_g);
      check("R9", "bus_addr_oe", bus_addr_oe, !m_g);
      check("R9", "bus_ctl_oe", bus_ctl_oe, !m_g);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    at_neg();
    // R1 reset state
    check("R1", "dma_gnt", dma_gnt, 0);
    check("R1", "bus_as", bus_as, 0);
    check("R1", "strobes", {bus_rd, bus_wr, bus_data_oe}, 0);
    check("R1", "core_done", core_done, 0);
    check("R1", "oe", {bus_addr_oe, bus_ctl_oe}, 2'b11);
    check("R1", "core_ready", core_ready, 1);
    compare_on = 1;

    // R8: request between boundaries, and boundary with interrupt pending
    step(); dma_req = 1;
    step(); at_neg(); check("R8", "no grant mid-instruction", dma_gnt, 0);
    step(); instr_boundary = 1; irq_pending = 1;
    step(); instr_boundary = 0; irq_pending = 0;
    at_neg(); check("R8", "irq blocks grant", dma_gnt, 0);
    // R7: qualifying boundary grants next edge
    step(); instr_boundary = 1;
    step(); instr_boundary = 0;
    at_neg(); check("R7", "grant after boundary", dma_gnt, 1);
    // R10: release one edge after request drops
    step(); dma_req = 0; core_req = 1; core_addr = 10'h3ff; core_write = 0;
    at_neg(); check("R10", "grant held in drop cycle", dma_gnt, 1);
    check("R10", "no start in drop cycle", core_ready, 0);
    step(); at_neg(); check("R10", "grant gone", dma_gnt, 0);
    check("R10", "cycle starts", core_ready, 1);
    step(); core_req = 0;
    repeat (4) step();
    // R11: peripheral wins a tie with the core
    dma_req = 1; instr_boundary = 1; core_req = 1; core_write = 1;
    at_neg(); check("R11", "core refused on tie", core_ready, 0);
    step(); instr_boundary = 0; core_req = 0;
    at_neg(); check("R11", "peripheral granted", dma_gnt, 1);
    check("R11", "no bus cycle", bus_as, 0);
    step(); dma_req = 0;
    repeat (2) step();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      core_req       = ($urandom % 2) == 0;
      core_write     = ($urandom % 2) == 0;
      core_addr      = AW'($urandom);
      core_wdata     = DW'($urandom);
      bus_rdata      = DW'($urandom);
      bus_wait       = ($urandom % 10) < 3;
      instr_boundary = ($urandom % 7) == 0;
      irq_pending    = ($urandom % 3) == 0;
      if (($urandom % 20) == 0) dma_req = !dma_req;
      step();
    end
    core_req = 0; dma_req = 0; instr_boundary = 0; bus_wait = 0;
    repeat (10) step();
    at_neg();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule